// File: doc/BRIEF.md
# PLL Configuration Register with Write Interlocks

This block holds the software-visible settings of one phase-locked loop. It stores the following: a reference clock source, a reference prescaler, an input-frequency range, a VCO range, three divider-output enables and a fractional-latch control bit. Software writes the register through a 32-bit port with byte strobes and reads it back through a separate read port. The PLL's own status (`pll_on`, `pll_rdy`) and a chip-wide flag that reports whether any PLL is running decide which fields accept a write. A write to a locked field is dropped silently. The other fields in the same write are still applied.

A rising edge of the fractional-latch bit copies an external fractional value into a holding register that feeds the modulator. When the copy happens, the block raises a one-cycle pulse for downstream logic. Keeping the bit at 1, or writing 1 again while it is already 1, makes no further copy.

Top module: `pll_cfg_reg`

## Requirements
- R1: After reset, every field, `rd_data`, `frac_held` and `frac_pulse` are 0.
- R2: The source field sits at bits [1:0] and is coded as follows: 0 = no clock, 1 = internal fast oscillator, 2 = internal low-power oscillator, 3 = external crystal. A write updates it only while `any_pll_en` is 0. At any other time the write leaves it unchanged.
- R3: The 6-bit prescaler sits at bits [13:8]. A write updates it only while both `pll_on` and `pll_rdy` are 0.
- R4: The input range field sits at bits [3:2], with codes 0..3 for 1-2, 2-4, 4-8 and 8-16 MHz. The VCO range bit sits at bit 4, with 0 = wide and 1 = medium. A write updates both only while `pll_on` is 0. `pll_rdy` does not block them.
- R5: The P, Q and R output enables sit at bits 16, 17 and 18. A write updates them whatever the PLL status.
- R6: A field changes only when the byte-strobe bit for its byte is set: bits [7:0] use strobe 0, bits [15:8] use strobe 1 and bits [23:16] use strobe 2.
- R7: `rd_data` shows the current field values in the same cycle that they update. All unused bit positions read 0.
- R8: A write that takes the latch bit (bit 5) from 0 to 1 has these effects on the next clock edge. The value on `frac_in` is copied into `frac_held`, and `frac_pulse` is high for exactly one cycle. `frac_held` changes at no other time.
- R9: No copy happens and no pulse is raised while the latch bit stays at 1, including when 1 is written again.
- R10: The latch bit can be written at any time and reads back at bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes for the write |
| rd_data | output | 32 | Current register contents |
| pll_on | input | 1 | PLL enabled status |
| pll_rdy | input | 1 | PLL locked status |
| any_pll_en | input | 1 | High when any PLL in the chip is enabled |
| frac_in | input | 13 | Fractional value to be latched |
| src_sel | output | 2 | Reference source selection |
| prescale | output | 6 | Reference prescaler value |
| in_range | output | 2 | Input frequency range code |
| vco_medium | output | 1 | VCO range (1 = medium) |
| p_out_en | output | 1 | P divider output enable |
| q_out_en | output | 1 | Q divider output enable |
| r_out_en | output | 1 | R divider output enable |
| frac_held | output | 13 | Fractional value held for the modulator |
| frac_pulse | output | 1 | One-cycle marker of a fractional transfer |

## Verification
The field registers take a write on the same clock edge that samples `wr_en`. The bench therefore reads `rd_data` and the field outputs at the falling edge that follows that write edge. The fractional transfer comes one edge later, because the latch bit must first be registered and then compared with its previous value. The bench checks at that first falling edge that no transfer has happened yet, then checks `frac_held` and `frac_pulse` at the next falling edge and again one cycle later. All inputs change on falling edges, so status and data are settled before the edge that samples them.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  // Bit layout of the register word
  localparam int SRC_LSB   = 0;
  localparam int SRC_W     = 2;
  localparam int RNG_LSB   = 2;
  localparam int RNG_W     = 2;
  localparam int VCO_BIT   = 4;
  localparam int LATCH_BIT = 5;
  localparam int DIV_LSB   = 8;
  localparam int PEN_BIT   = 16;
  localparam int QEN_BIT   = 17;
  localparam int REN_BIT   = 18;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF        = 2'd0,
    SRC_INT_FAST   = 2'd1,
    SRC_INT_LOWPWR = 2'd2,
    SRC_EXT_XTAL   = 2'd3
  } src_sel_e;

endpackage

// File: rtl/pll_cfg_field.sv
module pll_cfg_field #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lane_we,
  input  logic         allow,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (lane_we && allow) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pll_cfg_frac.sv
module pll_cfg_frac #(
  parameter int FRAC_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_bit,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [FRAC_W-1:0] frac_held,
  output logic              frac_pulse
);

  logic latch_d;
  logic take;

  assign take = latch_bit && !latch_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_d    <= 1'b0;
      frac_held  <= '0;
      frac_pulse <= 1'b0;
    end else begin
      latch_d    <= latch_bit;
      frac_pulse <= take;
      if (take) begin
        frac_held <= frac_in;
      end
    end
  end

  AST_HELD_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    !frac_pulse |-> $stable(frac_held)); // R8
  AST_PULSE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    frac_pulse |-> $past(latch_bit)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frac_pulse |=> !frac_pulse); // R9

endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_cfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 6,
  parameter int FRAC_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pll_on,
  input  logic              pll_rdy,
  input  logic              any_pll_en,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [SRC_W-1:0]  src_sel,
  output logic [DIV_W-1:0]  prescale,
  output logic [RNG_W-1:0]  in_range,
  output logic              vco_medium,
  output logic              p_out_en,
  output logic              q_out_en,
  output logic              r_out_en,
  output logic [FRAC_W-1:0] frac_held,
  output logic              frac_pulse
);

  localparam int STRB_W = DATA_W / 8;

  logic [STRB_W-1:0] lane_we;
  logic allow_src, allow_div, allow_rng;
  logic latch_q;
  logic unused_wr_bits;

  assign lane_we   = wr_en ? wr_strb : '0;
  assign allow_src = !any_pll_en;
  assign allow_div = !(pll_on || pll_rdy);
  assign allow_rng = !pll_on;
  assign unused_wr_bits = ^{wr_data, wr_strb};

  pll_cfg_field #(.W(SRC_W)) u_src (
    .clk(clk), .rst(rst), .lane_we(lane_we[SRC_LSB/8]), .allow(allow_src),
    .d(wr_data[SRC_LSB +: SRC_W]), .q(src_sel));

  pll_cfg_field #(.W(RNG_W)) u_rng (
    .clk(clk), .rst(rst), .lane_we(lane_we[RNG_LSB/8]), .allow(allow_rng),
    .d(wr_data[RNG_LSB +: RNG_W]), .q(in_range));

  pll_cfg_field #(.W(1)) u_vco (
    .clk(clk), .rst(rst), .lane_we(lane_we[VCO_BIT/8]), .allow(allow_rng),
    .d(wr_data[VCO_BIT]), .q(vco_medium));

  pll_cfg_field #(.W(1)) u_latch (
    .clk(clk), .rst(rst), .lane_we(lane_we[LATCH_BIT/8]), .allow(1'b1),
    .d(wr_data[LATCH_BIT]), .q(latch_q));

  pll_cfg_field #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .lane_we(lane_we[DIV_LSB/8]), .allow(allow_div),
    .d(wr_data[DIV_LSB +: DIV_W]), .q(prescale));

  // Three output enables share one pattern: generate them
  localparam int NUM_EN = 3;
  logic [NUM_EN-1:0] en_q;
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    pll_cfg_field #(.W(1)) u_en (
      .clk(clk), .rst(rst), .lane_we(lane_we[(PEN_BIT+g)/8]), .allow(1'b1),
      .d(wr_data[PEN_BIT+g]), .q(en_q[g]));
  end
  assign p_out_en = en_q[0];
  assign q_out_en = en_q[1];
  assign r_out_en = en_q[2];

  pll_cfg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .latch_bit(latch_q), .frac_in(frac_in),
    .frac_held(frac_held), .frac_pulse(frac_pulse));

  always_comb begin
    rd_data = '0;
    rd_data[SRC_LSB +: SRC_W] = src_sel;
    rd_data[RNG_LSB +: RNG_W] = in_range;
    rd_data[VCO_BIT]          = vco_medium;
    rd_data[LATCH_BIT]        = latch_q;
    rd_data[DIV_LSB +: DIV_W] = prescale;
    rd_data[PEN_BIT]          = en_q[0];
    rd_data[QEN_BIT]          = en_q[1];
    rd_data[REN_BIT]          = en_q[2];
  end

  AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    any_pll_en |=> $stable(src_sel)); // R2
  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (pll_on || pll_rdy) |=> $stable(prescale)); // R3
  AST_RANGE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    pll_on |=> $stable({in_range, vco_medium})); // R4
  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data)); // R6

endmodule

// File: tb/pll_cfg_reg_test.sv
`timescale 1ns/1ps
module pll_cfg_reg_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] rd_data;
  logic        pll_on = 1'b0, pll_rdy = 1'b0, any_pll_en = 1'b0;
  logic [12:0] frac_in = '0;
  logic [1:0]  src_sel;
  logic [5:0]  prescale;
  logic [1:0]  in_range;
  logic        vco_medium, p_out_en, q_out_en, r_out_en;
  logic [12:0] frac_held;
  logic        frac_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pll_cfg_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_data(rd_data), .pll_on(pll_on), .pll_rdy(pll_rdy),
    .any_pll_en(any_pll_en), .frac_in(frac_in), .src_sel(src_sel),
    .prescale(prescale), .in_range(in_range), .vco_medium(vco_medium),
    .p_out_en(p_out_en), .q_out_en(q_out_en), .r_out_en(r_out_en),
    .frac_held(frac_held), .frac_pulse(frac_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, apply at the rising edge, return at the next falling edge
  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_strb = '0;
  endtask

  task automatic status(input logic on, input logic rdy, input logic any);
    pll_on = on; pll_rdy = rdy; any_pll_en = any;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 frac_held", {19'b0, frac_held}, 32'h0);
    chk("R1 frac_pulse", {31'b0, frac_pulse}, 32'h0);
  endtask

  task automatic t_src;
    status(0, 0, 0);
    wr(32'h2, 4'b0001);
    chk("R2 src low-power", {30'b0, src_sel}, 32'h2);
    status(1, 1, 1);
    wr(32'h3, 4'b0001);
    chk("R2 src locked", {30'b0, src_sel}, 32'h2);
    status(0, 0, 0);
    wr(32'h3, 4'b0001);
    chk("R2 src crystal", {30'b0, src_sel}, 32'h3);
  endtask

  task automatic t_div_rng;
    status(1, 0, 0);
    wr(32'h0000_2000, 4'b0010);
    chk("R3 div blocked by on", {26'b0, prescale}, 32'h0);
    status(0, 1, 0);
    wr(32'h0000_2000, 4'b0010);
    chk("R3 div blocked by rdy", {26'b0, prescale}, 32'h0);
    // range and VCO accept while only rdy is high; src kept at 3
    wr(32'h0000_001F, 4'b0001);
    chk("R4 range ok under rdy", {30'b0, in_range}, 32'h3);
    chk("R4 vco ok under rdy", {31'b0, vco_medium}, 32'h1);
    status(0, 0, 0);
    wr(32'h0000_2000, 4'b0010);
    chk("R3 div written", {26'b0, prescale}, 32'h20);
    status(1, 0, 0);
    wr(32'h0000_0007, 4'b0001);
    chk("R4 range blocked", {30'b0, in_range}, 32'h3);
    chk("R4 vco blocked", {31'b0, vco_medium}, 32'h1);
  endtask

  task automatic t_enables;
    status(1, 1, 1);
    wr(32'h0007_0000, 4'b0100);
    chk("R5 enables under lock", {29'b0, r_out_en, q_out_en, p_out_en}, 32'h7);
    wr(32'h0002_0000, 4'b0100);
    chk("R5 only Q", {29'b0, r_out_en, q_out_en, p_out_en}, 32'h2);
    status(0, 0, 0);
  endtask

  task automatic t_strobe_layout;
    // only lane 2 strobed: lanes 0 and 1 must hold (src 3, range 3, vco 1, div 0x20)
    wr(32'hFFFF_FF00, 4'b0100);
    chk("R6 lane 2 only", rd_data, 32'h0007_201F);
    wr(32'h0000_0000, 4'b0000);
    chk("R6 no strobe", rd_data, 32'h0007_201F);
    wr(32'hFFFF_FFDF, 4'b1111);
    chk("R7 layout unused zero", rd_data, 32'h0007_3F1F);
    wr(32'h0, 4'b1111);
    chk("R7 cleared", rd_data, 32'h0);
  endtask

  task automatic t_frac;
    frac_in = 13'h1ABC;
    wr(32'h20, 4'b0001);
    chk("R10 latch bit reads back", {31'b0, rd_data[5]}, 32'h1);
    chk("R8 no pulse yet", {31'b0, frac_pulse}, 32'h0);
    chk("R8 held not yet", {19'b0, frac_held}, 32'h0);
    @(negedge clk);
    chk("R8 pulse", {31'b0, frac_pulse}, 32'h1);
    chk("R8 held copied", {19'b0, frac_held}, 32'h1ABC);
    frac_in = 13'h0555;
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, frac_pulse}, 32'h0);
    chk("R9 held while bit stays 1", {19'b0, frac_held}, 32'h1ABC);
    status(1, 1, 1);
    wr(32'h20, 4'b0001);
    chk("R9 rewrite no pulse a", {31'b0, frac_pulse}, 32'h0);
    @(negedge clk);
    chk("R9 rewrite no pulse b", {31'b0, frac_pulse}, 32'h0);
    chk("R9 rewrite held", {19'b0, frac_held}, 32'h1ABC);
    wr(32'h00, 4'b0001);
    chk("R10 latch cleared under lock", {31'b0, rd_data[5]}, 32'h0);
    @(negedge clk);
    frac_in = 13'h0777;
    wr(32'h20, 4'b0001);
    @(negedge clk);
    chk("R8 second pulse", {31'b0, frac_pulse}, 32'h1);
    chk("R8 second copy", {19'b0, frac_held}, 32'h0777);
    status(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_src();
    t_div_rng();
    t_enables();
    t_strobe_layout();
    t_frac();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule